// File: doc/BRIEF.md
# MESI Snooping Direct-Mapped L1 Data Cache Controller

This block is the coherence and lookup controller of one processor's private L1 data cache in a bus-based shared-memory system. Each line carries a tag and one of four MESI states. No data values are stored, so the block models the hit and miss behaviour, the coherence traffic and the timing of a real cache. The processor offers one request per cycle: a 2-bit access kind and a 32-bit byte address. Data reads and data writes look up the line chosen by the index bits of the address. Instruction fetches are accepted and take their cycle, but they leave the cache and the counters alone.

The cache is direct-mapped, write-back and write-allocate, and it blocks. After a miss it stops accepting processor requests. It may first emit a write-back pulse for a dirty victim. It then requests the bus for a read or read-exclusive, and it installs the line ten cycles after the grant. A write to a Shared copy issues an upgrade instead. Snoops from other caches are served in every cycle, including the cycles of its own miss. A snoop may also kill a pending upgrade, which is then turned into a read-exclusive. Two saturating counters give the number of data accesses and data misses, from which the miss ratio follows.

Top module: `mesi_l1_ctrl`

## Requirements
- R1: After reset every line is Invalid, both counters read zero, `req_ready` is high, and `bus_req_valid` and `wb_valid` are low.
- R2: A read miss (req_type 2) drives a bus request with cmd 1 (read) at the block-aligned address and holds it until `bus_grant`. The line is installed so that `req_ready` returns 11 sampling cycles after the grant cycle (a 10-cycle fill). The line is installed Exclusive if `bus_shared_in` was low at the grant, and Shared if it was high.
- R3: A write miss (req_type 3) issues cmd 2 (read-exclusive) with the same fill timing, and the line is installed Modified.
- R4: A write hit on a Shared line issues cmd 3 (upgrade). The line becomes Modified at the grant, and `req_ready` is high in the next cycle. A write hit on Exclusive becomes Modified with no bus request. Read hits and write hits on Modified issue no bus request and are ready again in the next cycle.
- R5: A miss whose victim line is Modified raises `wb_valid` for one cycle with the victim's block address, before the bus request starts. A clean or Invalid victim raises no pulse.
- R6: A snoop with cmd 1 that hits a valid line asserts `snp_shared`. It asserts `snp_flush` if the line is Modified, and it leaves the line Shared.
- R7: A snoop with cmd 2 or 3 that hits a line invalidates it and does not assert `snp_shared`. A Modified line also asserts `snp_flush`. A snoop that hits nothing asserts neither output.
- R8: Snoops are served while a fill is pending, and they do not change the fill timing.
- R9: If a pending upgrade's line is invalidated by a snoop before the grant, the request changes to cmd 2 and completes as a full fill that installs Modified.
- R10: Requests of type 0 (fetch) and type 1 (unused) take one cycle and change neither the lines nor the counters.
- R11: `acc_count` increments once per accepted type 2 or 3 request. `miss_count` increments once per accepted request whose line was absent at acceptance; upgrades are not misses. Both counters saturate at all ones.
- R12: `req_ready` is low while a miss or upgrade is in progress and in any cycle with `snp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_type | input | 2 | 0 fetch, 1 unused, 2 data read, 3 data write |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Request accepted in this cycle if valid |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_addr | output | 32 | Block-aligned address of the transaction |
| bus_grant | input | 1 | Bus granted to this cache in this cycle |
| bus_shared_in | input | 1 | Another cache holds the block (sampled at grant) |
| wb_valid | output | 1 | One-cycle write-back of a dirty victim |
| wb_addr | output | 32 | Block address of the victim |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | 32 | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped block (read snoop) |
| snp_flush | output | 1 | This cache supplies the dirty block |
| acc_count | output | 32 | Saturating data access count |
| miss_count | output | 32 | Saturating data miss count |

## Verification
A request is accepted at a rising edge. Hit results, counter updates and `req_ready` are read at the falling edge that follows. A write-back pulse shows in the cycle after acceptance, and the bus request shows one cycle after that, or in the first cycle if there is no victim. After a grant, `req_ready` is counted in falling edges: it is due at the 11th for a fill and at the 1st for an upgrade. The snoop outputs are combinational, so they are sampled shortly after the snoop is driven at a falling edge. Each line's hidden state is read back through the bus traffic that a later access causes.

// File: rtl/mesi_pkg.sv
// Shared encodings for the MESI L1 controller.
// Assumes 2-bit request kinds and 2-bit bus commands as listed in the brief.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPGR = 2'd3
    } bus_cmd_t;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd2;
    localparam logic [1:0] KIND_WRITE = 2'd3;
endpackage

// File: rtl/mesi_line_store.sv
// Tag and state storage, one register set per line.
// Two read ports (processor, snoop) and two write ports. A processor-side
// write wins over a snoop write to the same line in the same cycle.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  p_rd_idx,
    output logic [TAG_W-1:0]  p_rd_tag,
    output line_state_t       p_rd_state,
    input  logic [IDX_W-1:0]  s_rd_idx,
    output logic [TAG_W-1:0]  s_rd_tag,
    output line_state_t       s_rd_state,
    input  logic              p_we,
    input  logic [IDX_W-1:0]  p_wr_idx,
    input  logic [TAG_W-1:0]  p_wr_tag,
    input  line_state_t       p_wr_state,
    input  logic              s_we,
    input  line_state_t       s_wr_state
);
    logic [TAG_W-1:0] tags  [LINES];
    line_state_t      state [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Update one line's tag and MESI state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[g]  <= '0;
                state[g] <= ST_I;
            end else if (p_we && (p_wr_idx == IDX_W'(g))) begin
                tags[g]  <= p_wr_tag;
                state[g] <= p_wr_state;
            end else if (s_we && (s_rd_idx == IDX_W'(g))) begin
                state[g] <= s_wr_state;
            end
        end
    end

    // Read both ports combinationally.
    always_comb begin
        p_rd_tag   = tags[p_rd_idx];
        p_rd_state = state[p_rd_idx];
        s_rd_tag   = tags[s_rd_idx];
        s_rd_state = state[s_rd_idx];
    end
endmodule

// File: rtl/mesi_snoop_unit.sv
// Snoop response logic: decides shared and flush replies and the new state
// of the snooped line. Purely combinational; assumes the caller provides the
// stored tag and state at the snooped index.
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_state_t      line_state,
    output logic             snp_shared,
    output logic             snp_flush,
    output logic             upd_we,
    output line_state_t      upd_state,
    output logic             kill_hit
);
    logic hit;

    // Derive the snoop reply and line transition.
    always_comb begin
        hit        = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
        snp_shared = 1'b0;
        snp_flush  = 1'b0;
        upd_we     = 1'b0;
        upd_state  = line_state;
        kill_hit   = 1'b0;
        case (bus_cmd_t'(snp_cmd))
            CMD_RD: begin
                snp_shared = hit;
                snp_flush  = hit && (line_state == ST_M);
                upd_we     = hit && (line_state != ST_S);
                upd_state  = ST_S;
            end
            CMD_RDX, CMD_UPGR: begin
                snp_flush  = hit && (line_state == ST_M);
                upd_we     = hit;
                upd_state  = ST_I;
                kill_hit   = hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_stat_counters.sv
// Saturating access and miss counters. Assumes one increment pulse per
// accepted request at most.
module mesi_stat_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_acc,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] acc_count,
    output logic [CNT_W-1:0] miss_count
);
    // Count accesses, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_count <= '0;
        else if (inc_acc && (acc_count != '1)) acc_count <= acc_count + 1'b1;
    end

    // Count misses, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_count <= '0;
        else if (inc_miss && (miss_count != '1)) miss_count <= miss_count + 1'b1;
    end
endmodule

// File: rtl/mesi_ctrl_fsm.sv
// Processor-side sequencer: lookup, victim write-back, bus request, fill
// wait and line install. Assumes the bus never delivers a snoop in the same
// cycle as this cache's own grant.
module mesi_ctrl_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int TAG_W       = 20,
    parameter int OFF_W       = 6,
    parameter int FILL_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_type,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_ready,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_state_t       line_state,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [TAG_W+IDX_W+OFF_W-1:0] bus_req_addr,
    output logic              wb_valid,
    output logic [TAG_W+IDX_W+OFF_W-1:0] wb_addr,
    input  logic              snp_valid,
    input  logic              snp_kill,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic              p_we,
    output logic [IDX_W-1:0]  p_wr_idx,
    output logic [TAG_W-1:0]  p_wr_tag,
    output line_state_t       p_wr_state,
    output logic              inc_acc,
    output logic              inc_miss
);
    localparam int FCNT_W = $clog2(FILL_CYCLES + 1);

    typedef enum logic [1:0] {SQ_IDLE, SQ_WB, SQ_REQ, SQ_FILL} seq_t;

    seq_t              seq;
    logic [TAG_W-1:0]  pend_tag;
    logic [IDX_W-1:0]  pend_idx;
    logic [TAG_W-1:0]  victim_tag;
    bus_cmd_t          cmd_r;
    logic              shared_r;
    logic [FCNT_W-1:0] fill_cnt;

    logic accept_rw, hit, is_wr, lost_upgr;

    // Decode the lookup and drive the combinational outputs of each step.
    always_comb begin
        req_ready     = (seq == SQ_IDLE) && !snp_valid;
        accept_rw     = req_valid && req_ready && req_type[1];
        is_wr         = (req_type == KIND_WRITE);
        hit           = (line_state != ST_I) && (line_tag == req_tag);
        lost_upgr     = (cmd_r == CMD_UPGR) && snp_valid && snp_kill && (snp_idx == pend_idx);
        bus_req_valid = (seq == SQ_REQ);
        bus_req_cmd   = cmd_r;
        bus_req_addr  = {pend_tag, pend_idx, {OFF_W{1'b0}}};
        wb_valid      = (seq == SQ_WB);
        wb_addr       = {victim_tag, pend_idx, {OFF_W{1'b0}}};
        p_we          = 1'b0;
        p_wr_idx      = pend_idx;
        p_wr_tag      = pend_tag;
        p_wr_state    = ST_I;
        inc_acc       = accept_rw;
        inc_miss      = accept_rw && !hit;
        case (seq)
            SQ_IDLE: begin
                p_wr_idx = req_idx;
                p_wr_tag = line_tag;
                if (accept_rw && !hit) begin
                    p_we       = 1'b1;
                    p_wr_state = ST_I;
                end else if (accept_rw && is_wr && (line_state == ST_E)) begin
                    p_we       = 1'b1;
                    p_wr_state = ST_M;
                end
            end
            SQ_REQ: begin
                if ((cmd_r == CMD_UPGR) && bus_grant && !lost_upgr) begin
                    p_we       = 1'b1;
                    p_wr_state = ST_M;
                end
            end
            SQ_FILL: begin
                if (fill_cnt == '0) begin
                    p_we       = 1'b1;
                    p_wr_state = (cmd_r == CMD_RDX) ? ST_M : (shared_r ? ST_S : ST_E);
                end
            end
            default: ;
        endcase
    end

    // Advance the miss sequence and hold the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq        <= SQ_IDLE;
            pend_tag   <= '0;
            pend_idx   <= '0;
            victim_tag <= '0;
            cmd_r      <= CMD_RD;
            shared_r   <= 1'b0;
            fill_cnt   <= '0;
        end else begin
            case (seq)
                SQ_IDLE: begin
                    if (accept_rw && !hit) begin
                        pend_tag   <= req_tag;
                        pend_idx   <= req_idx;
                        victim_tag <= line_tag;
                        cmd_r      <= is_wr ? CMD_RDX : CMD_RD;
                        seq        <= (line_state == ST_M) ? SQ_WB : SQ_REQ;
                    end else if (accept_rw && is_wr && (line_state == ST_S)) begin
                        pend_tag <= req_tag;
                        pend_idx <= req_idx;
                        cmd_r    <= CMD_UPGR;
                        seq      <= SQ_REQ;
                    end
                end
                SQ_WB: seq <= SQ_REQ;
                SQ_REQ: begin
                    if (lost_upgr) begin
                        cmd_r <= CMD_RDX;
                    end else if (bus_grant) begin
                        if (cmd_r == CMD_UPGR) begin
                            seq <= SQ_IDLE;
                        end else begin
                            shared_r <= bus_shared_in;
                            fill_cnt <= FCNT_W'(FILL_CYCLES - 1);
                            seq      <= SQ_FILL;
                        end
                    end
                end
                SQ_FILL: begin
                    if (fill_cnt == '0) seq <= SQ_IDLE;
                    else fill_cnt <= fill_cnt - 1'b1;
                end
                default: seq <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mesi_l1_ctrl.sv
// Top of the MESI L1 data cache controller. Splits addresses into tag,
// index and offset, and wires the line store, snoop unit, sequencer and
// counters. Assumes power-of-two capacity and block size.
module mesi_l1_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 4096,
    parameter int BLOCK_BYTES = 64,
    parameter int FILL_CYCLES = 10,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CNT_W-1:0]  miss_count
);
    import mesi_pkg::*;

    localparam int LINES = CACHE_BYTES / BLOCK_BYTES;
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0] req_idx, snp_idx, p_wr_idx;
    logic [TAG_W-1:0] req_tag, snp_tag, p_tag, s_tag, p_wr_tag;
    line_state_t      p_state, s_state, p_wr_state, s_wr_state;
    logic             p_we, s_we, snp_kill, inc_acc, inc_miss;
    logic             unused_offsets;

    assign req_idx        = req_addr[OFF_W +: IDX_W];
    assign req_tag        = req_addr[ADDR_W-1 -: TAG_W];
    assign snp_idx        = snp_addr[OFF_W +: IDX_W];
    assign snp_tag        = snp_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{req_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

    mesi_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .p_rd_idx(req_idx), .p_rd_tag(p_tag), .p_rd_state(p_state),
        .s_rd_idx(snp_idx), .s_rd_tag(s_tag), .s_rd_state(s_state),
        .p_we(p_we), .p_wr_idx(p_wr_idx), .p_wr_tag(p_wr_tag), .p_wr_state(p_wr_state),
        .s_we(s_we), .s_wr_state(s_wr_state)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_tag),
        .line_tag(s_tag), .line_state(s_state),
        .snp_shared(snp_shared), .snp_flush(snp_flush),
        .upd_we(s_we), .upd_state(s_wr_state), .kill_hit(snp_kill)
    );

    mesi_ctrl_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .FILL_CYCLES(FILL_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type), .req_idx(req_idx), .req_tag(req_tag),
        .req_ready(req_ready), .line_tag(p_tag), .line_state(p_state),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr),
        .snp_valid(snp_valid), .snp_kill(snp_kill), .snp_idx(snp_idx),
        .p_we(p_we), .p_wr_idx(p_wr_idx), .p_wr_tag(p_wr_tag), .p_wr_state(p_wr_state),
        .inc_acc(inc_acc), .inc_miss(inc_miss)
    );

    mesi_stat_counters #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .inc_acc(inc_acc), .inc_miss(inc_miss),
        .acc_count(acc_count), .miss_count(miss_count)
    );
endmodule

// File: rtl/mesi_l1_checker.sv
// Protocol checks on the ports of the MESI L1 controller, bound to the top.
module mesi_l1_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_grant,
    input logic              wb_valid,
    input logic              snp_valid,
    input logic              snp_flush,
    input logic [CNT_W-1:0]  acc_count,
    input logic [CNT_W-1:0]  miss_count
);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_grant) |=> (bus_req_valid && $stable(bus_req_addr)));

    assert_fill_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_grant && (bus_req_cmd != 2'd3)) |=> !req_ready);

    assert_upgr_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_grant && (bus_req_cmd == 2'd3)) |=> (req_ready || snp_valid));

    assert_wb_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !bus_req_valid);

    assert_wb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (bus_req_valid && !wb_valid));

    assert_flush_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_valid);

    assert_miss_le_acc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        miss_count <= acc_count);

    assert_acc_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc_count >= $past(acc_count)));

    assert_snoop_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !req_ready);

    assert_busy_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid || wb_valid) |-> !req_ready);
endmodule

bind mesi_l1_ctrl mesi_l1_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_grant(bus_grant), .wb_valid(wb_valid), .snp_valid(snp_valid), .snp_flush(snp_flush),
    .acc_count(acc_count), .miss_count(miss_count)
);

// File: tb/tb_mesi_l1_ctrl.sv
`timescale 1ns/100ps
module tb_mesi_l1_ctrl;
    localparam int CW = 5;
    localparam int NV = 11;
    // {type, addr, shared_in, exp_cmd, exp_wb, exp_miss, exp_wb_addr}
    localparam logic [70:0] VEC [NV] = '{
        {2'd2, 32'h0000104A, 1'b0, 2'd1, 1'b0, 1'b1, 32'h0},          // R2 read miss -> E
        {2'd3, 32'h0000104A, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0},          // R4 E -> M silent
        {2'd2, 32'h00002042, 1'b1, 2'd1, 1'b1, 1'b1, 32'h00001040},   // R5 dirty victim, S fill
        {2'd3, 32'h00002042, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0},          // R4 S -> upgrade
        {2'd0, 32'h00005000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0},          // R10 fetch
        {2'd3, 32'h00003086, 1'b0, 2'd2, 1'b0, 1'b1, 32'h0},          // R3 write miss
        {2'd2, 32'h00003080, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0},          // R4 read hit on M
        {2'd2, 32'h00001040, 1'b0, 2'd1, 1'b1, 1'b1, 32'h00002040},   // R5 victim M after upgrade
        {2'd1, 32'h00003080, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0},          // R10 unused kind
        {2'd2, 32'h000040FE, 1'b1, 2'd1, 1'b0, 1'b1, 32'h0},          // R2 shared fill
        {2'd2, 32'h000040C0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0}           // R4 read hit on S
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, bus_grant = 1'b0, bus_shared_in = 1'b0, snp_valid = 1'b0;
    logic [1:0] req_type = 2'd0, snp_cmd = 2'd0;
    logic [31:0] req_addr = '0, snp_addr = '0;
    logic req_ready, bus_req_valid, wb_valid, snp_shared, snp_flush;
    logic [1:0] bus_req_cmd;
    logic [31:0] bus_req_addr, wb_addr;
    logic [CW-1:0] acc_count, miss_count;

    int n_chk = 0, n_fail = 0, exp_acc = 0, exp_miss = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mesi_l1_ctrl #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_ready(req_ready), .bus_req_valid(bus_req_valid),
        .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr), .bus_grant(bus_grant),
        .bus_shared_in(bus_shared_in), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush),
        .acc_count(acc_count), .miss_count(miss_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic counts(input string tag);
        chk({tag, " acc_count R11"}, 32'(acc_count), 32'((exp_acc > 31) ? 31 : exp_acc));
        chk({tag, " miss_count R11"}, 32'(miss_count), 32'(exp_miss));
    endtask

    // Present one request and serve its bus traffic; returns what was seen.
    task automatic run_access(input logic [1:0] t, input logic [31:0] a, input logic shr,
                              output logic [1:0] cmd, output logic [31:0] badr,
                              output logic wb, output logic [31:0] wba, output int lat);
        cmd = 2'd0; badr = '0; wb = 1'b0; wba = '0; lat = 0;
        @(negedge clk);
        req_valid = 1'b1; req_type = t; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (t[1]) exp_acc++;
        for (int k = 0; k < 40; k++) begin
            if (wb_valid) begin wb = 1'b1; wba = wb_addr; end
            if (bus_req_valid) begin
                cmd = bus_req_cmd; badr = bus_req_addr;
                bus_shared_in = shr; bus_grant = 1'b1;
                @(negedge clk);
                bus_grant = 1'b0; bus_shared_in = 1'b0; lat = 1;
                while (!req_ready && lat < 40) begin @(negedge clk); lat++; end
                break;
            end
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic snoop(input logic [1:0] c, input logic [31:0] a,
                         output logic shd, output logic fl, output logic rdy);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        shd = snp_shared; fl = snp_flush; rdy = req_ready;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] cmd; logic [31:0] badr, wba; logic wb, shd, fl, rdy; int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 bus_req_valid", 32'(bus_req_valid), 32'd0);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        counts("R1");

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [70:0] e;
            e = VEC[v];
            run_access(e[70:69], e[68:37], e[36], cmd, badr, wb, wba, lat);
            if (e[32]) exp_miss++;
            chk($sformatf("vec%0d bus cmd R2 R3 R4", v), 32'(cmd), 32'(e[35:34]));
            if (e[35:34] != 2'd0) begin
                chk($sformatf("vec%0d bus addr R2", v), badr, e[68:37] & 32'hFFFF_FFC0);
                chk($sformatf("vec%0d ready latency R2 R4", v), 32'(lat),
                    (e[35:34] == 2'd3) ? 32'd1 : 32'd11);
            end
            chk($sformatf("vec%0d wb pulse R5", v), 32'(wb), 32'(e[33]));
            if (e[33]) chk($sformatf("vec%0d wb addr R5", v), wba, e[31:0]);
            chk($sformatf("vec%0d ready after R10", v), 32'(req_ready), 32'd1);
            counts($sformatf("vec%0d", v));
        end

        // R6 R12: read snoop on Exclusive line A, stall while snooped
        snoop(2'd1, 32'h00001040, shd, fl, rdy);
        chk("R6 shared on E", 32'(shd), 32'd1);
        chk("R6 no flush on E", 32'(fl), 32'd0);
        chk("R12 ready low under snoop", 32'(rdy), 32'd0);
        run_access(2'd3, 32'h00001040, 1'b0, cmd, badr, wb, wba, lat);
        chk("R6 line left Shared (upgrade)", 32'(cmd), 32'd3);

        // R6 R7: A now Modified
        snoop(2'd1, 32'h00001040, shd, fl, rdy);
        chk("R6 shared on M", 32'(shd), 32'd1);
        chk("R6 flush on M", 32'(fl), 32'd1);
        snoop(2'd2, 32'h00001040, shd, fl, rdy);
        chk("R7 no shared on rdx", 32'(shd), 32'd0);
        chk("R7 no flush on S", 32'(fl), 32'd0);
        run_access(2'd2, 32'h00001040, 1'b0, cmd, badr, wb, wba, lat);
        exp_miss++;
        chk("R7 invalidated line misses", 32'(cmd), 32'd1);
        snoop(2'd1, 32'h00009000, shd, fl, rdy);
        chk("R7 absent block shared", 32'(shd), 32'd0);
        chk("R7 absent block flush", 32'(fl), 32'd0);
        counts("R7");

        // R8: snoop served during a fill of F
        @(negedge clk);
        req_valid = 1'b1; req_type = 2'd2; req_addr = 32'h00005100;
        @(negedge clk);
        req_valid = 1'b0; exp_acc++; exp_miss++;
        chk("R8 bus read for F", 32'(bus_req_valid && bus_req_cmd == 2'd1), 32'd1);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0; lat = 1;
        @(negedge clk); lat++;
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 32'h00003080;
        #1;
        chk("R8 R7 flush of M during fill", 32'(snp_flush), 32'd1);
        @(negedge clk); lat++;
        snp_valid = 1'b0; snp_cmd = 2'd0;
        while (!req_ready && lat < 40) begin @(negedge clk); lat++; end
        chk("R8 fill timing unchanged", 32'(lat), 32'd11);
        run_access(2'd2, 32'h00003080, 1'b0, cmd, badr, wb, wba, lat);
        exp_miss++;
        chk("R8 snooped line now misses", 32'(cmd), 32'd1);
        chk("R8 no write-back of invalidated", 32'(wb), 32'd0);

        // R9: upgrade lost to a snoop, reissued as read-exclusive
        @(negedge clk);
        req_valid = 1'b1; req_type = 2'd3; req_addr = 32'h000040C0;
        @(negedge clk);
        req_valid = 1'b0; exp_acc++;
        chk("R9 upgrade requested", 32'(bus_req_valid && bus_req_cmd == 2'd3), 32'd1);
        snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = 32'h000040C0;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
        chk("R9 converted to rdx", 32'(bus_req_valid && bus_req_cmd == 2'd2), 32'd1);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0; lat = 1;
        while (!req_ready && lat < 40) begin @(negedge clk); lat++; end
        chk("R9 full fill latency", 32'(lat), 32'd11);
        snoop(2'd1, 32'h000040C0, shd, fl, rdy);
        chk("R9 installed Modified", 32'(fl), 32'd1);
        counts("R9");

        // R11: saturation with read hits on F
        for (int i = 0; i < 25; i++) run_access(2'd2, 32'h00005100, 1'b0, cmd, badr, wb, wba, lat);
        counts("R11 saturation");
        chk("R11 ready after hits", 32'(req_ready), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule